// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side, every low data bit is sent as one short active-high light pulse. A high bit sends no pulse. In normal mode the pulse is 3/16 of a bit period and is centred in the bit. In low-power mode the pulse width comes from a fixed-rate reference tick divided by a programmable divisor, so the width does not depend on the selected bit rate. On the receive side, each falling edge of the active-low infrared input turns the recovered bit low for one bit period. The UART framing itself is handled elsewhere.

The block also gates the ordinary wired serial line. While the infrared path is active, the wired TX line idles high and the wired RX line is ignored. While the infrared path is inactive, the wired lines pass straight through and the infrared output stays dark. The infrared path is active only when both the UART enable and the SIR enable are set. A test loopback can feed the inverted infrared output back into the decoder.

Bit timing is taken from a 16x oversampling tick. The encoder keeps a 16-phase counter that realigns on every falling edge of the TX bit. A UART changes its output only at bit boundaries, so this keeps the pulse position locked to the frame.

Top module: `sir_codec`

## Requirements
- R1: With the path active and low-power mode off, a TX bit of 0 held for 16 oversampling ticks produces exactly one high pulse on sir_tx_o. The pulse starts on the 8th tick of the bit and lasts 3 tick periods. A TX bit of 1 produces no pulse.
- R2: In low-power mode, a 0 bit produces one pulse that starts at the first low-power tick after the bit's 8th oversampling tick. The pulse lasts exactly 3 low-power tick periods, whatever the oversampling tick rate is.
- R3: The low-power tick occurs once every lp_div_i reference ticks. A divisor of 0 gives no low-power tick, and no pulse is sent in low-power mode.
- R4: With uart_en_i=1 and sir_en_i=0, sir_tx_o stays 0, sir_rxn_i is ignored, line_txd_o equals uart_txd_i and rx_bit_o equals line_rxd_i.
- R5: With the path active (uart_en_i=1 and sir_en_i=1), line_txd_o is held at 1 and line_rxd_i has no effect on rx_bit_o.
- R6: With uart_en_i=0, sir_en_i has no effect: the block behaves as in R4.
- R7: With the path active, a falling edge on sir_rxn_i (active-low pulse) drives rx_bit_o low within 3 clock cycles. rx_bit_o stays low for 16 to 17 oversampling tick periods and then returns to 1.
- R8: Pulses received in consecutive bit periods keep rx_bit_o low continuously, with no high gap between the bits.
- R9: With loop_en_i=1 and sir_test_i=1 on an active path, the decoder sees the inverse of sir_tx_o and sir_rxn_i is ignored. With only one of those two bits set, no loopback occurs.
- R10: After reset, sir_tx_o is 0 and, with the path active, rx_bit_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud16_tick_i | input | 1 | 16x oversampling tick, one cycle wide |
| lp_ref_tick_i | input | 1 | Fixed-rate reference tick for low-power timing |
| lp_div_i | input | DIV_W | Low-power divisor (0 = no low-power tick) |
| uart_en_i | input | 1 | UART enable |
| sir_en_i | input | 1 | Infrared path enable |
| lp_mode_i | input | 1 | Low-power pulse width select |
| loop_en_i | input | 1 | Loopback enable |
| sir_test_i | input | 1 | Infrared test mode; with loop_en_i, enables loopback |
| uart_txd_i | input | 1 | Serial TX bit from the UART |
| line_rxd_i | input | 1 | Wired serial RX line |
| sir_rxn_i | input | 1 | Infrared receiver input, active low |
| sir_tx_o | output | 1 | Infrared LED drive, active high |
| line_txd_o | output | 1 | Wired serial TX line |
| rx_bit_o | output | 1 | Recovered RX bit to the UART |

## Verification
Several internal faults show up at sir_tx_o on the very first 0 bit:
- If the phase counter does not realign on the falling edge, the pulse moves within the bit.
- A window that is off by one tick gives a pulse of 2 or 4 tick periods instead of 3.
- A wrong low-power arming or count gives a pulse that is not exactly 3 low-power periods wide.

A decoder hold count that is too short shows within one bit, either as a short low on rx_bit_o or as a high gap between consecutive received pulses. Faults in the gating or loopback selection show as pulses, or missing pulses, on the opposite path within the same bit.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int SIR_OVS       = 16;  // oversampling ticks per bit
  localparam int SIR_PULSE_LEN = 3;   // normal pulse, in ticks
  localparam int SIR_LP_LEN    = 3;   // low-power pulse, in low-power ticks
  localparam int SIR_DIV_W     = 8;

  typedef enum logic {
    PW_NORMAL = 1'b0,
    PW_LOWPWR = 1'b1
  } pw_mode_e;
endpackage

// File: rtl/sir_lp_div.sv
module sir_lp_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             div_ok;
  logic             wrap;

  assign div_ok = |div_i;
  assign wrap   = cnt_q >= (div_i - DIV_W'(1));
  assign tick_o = div_ok & ref_tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!div_ok)    cnt_q <= '0;
    else if (ref_tick_i) cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sir_enc.sv
module sir_enc import sir_pkg::*; #(
  parameter int OVS       = SIR_OVS,
  parameter int PULSE_LEN = SIR_PULSE_LEN,
  parameter int LP_LEN    = SIR_LP_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick16_i,
  input  logic lp_tick_i,
  input  logic active_i,
  input  logic lp_mode_i,
  input  logic lp_ok_i,
  input  logic txd_i,
  output logic pulse_o
);
  localparam int PH_W     = $clog2(OVS);
  localparam int PULSE_PH = OVS / 2 - PULSE_LEN / 2;
  localparam int LP_W     = $clog2(LP_LEN + 1);

  pw_mode_e        mode;
  logic            txd_q;
  logic [PH_W-1:0] ph_q, ph_nx;
  logic            fall, in_win, trig, lp_go;
  logic            norm_q, lp_arm_q, lp_on_q;
  logic [LP_W-1:0] lp_cnt_q;

  assign mode   = lp_mode_i ? PW_LOWPWR : PW_NORMAL;
  assign fall   = txd_q & ~txd_i;
  assign ph_nx  = fall ? '0 : ph_q + PH_W'(1);
  assign in_win = (int'(ph_nx) >= PULSE_PH) && (int'(ph_nx) < PULSE_PH + PULSE_LEN);
  assign trig   = tick16_i & active_i & ~txd_i & (int'(ph_nx) == PULSE_PH);
  assign lp_go  = active_i & (mode == PW_LOWPWR) & lp_ok_i;

  // bit phase, realigned on every falling edge of the TX bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q  <= 1'b1;
      ph_q   <= '0;
      norm_q <= 1'b0;
    end else if (tick16_i) begin
      txd_q  <= txd_i;
      ph_q   <= ph_nx;
      norm_q <= active_i & (mode == PW_NORMAL) & ~txd_i & in_win;
    end
  end

  // low-power pulse: armed at mid-bit, opens at next low-power tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_arm_q <= 1'b0;
      lp_on_q  <= 1'b0;
      lp_cnt_q <= '0;
    end else if (!lp_go) begin
      lp_arm_q <= 1'b0;
      lp_on_q  <= 1'b0;
      lp_cnt_q <= '0;
    end else begin
      if (lp_tick_i && lp_arm_q && !lp_on_q) begin
        lp_on_q  <= 1'b1;
        lp_arm_q <= 1'b0;
        lp_cnt_q <= '0;
      end else if (lp_tick_i && lp_on_q) begin
        if (lp_cnt_q == LP_W'(LP_LEN - 1)) lp_on_q <= 1'b0;
        lp_cnt_q <= lp_cnt_q + LP_W'(1);
      end
      if (trig) lp_arm_q <= 1'b1;
    end
  end

  assign pulse_o = active_i & ((mode == PW_LOWPWR) ? (lp_ok_i & lp_on_q) : norm_q);
endmodule

// File: rtl/sir_dec.sv
module sir_dec import sir_pkg::*; #(
  parameter int OVS        = SIR_OVS,
  parameter int HOLD_TICKS = SIR_OVS + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick16_i,
  input  logic active_i,
  input  logic rxn_i,
  output logic rx_o,
  output logic fall_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [2:0]    sync_q;
  logic [HW-1:0] hold_q;

  assign fall_o = sync_q[2] & ~sync_q[1];
  assign rx_o   = (hold_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[1:0], rxn_i};
  end

  // hold slightly over one bit so back-to-back pulses merge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hold_q <= '0;
    else if (!active_i)                hold_q <= '0;
    else if (fall_o)                   hold_q <= HW'(HOLD_TICKS);
    else if (tick16_i && hold_q != '0) hold_q <= hold_q - HW'(1);
  end

  initial if (HOLD_TICKS <= OVS) $error("hold must exceed one bit");
endmodule

// File: rtl/sir_codec.sv
module sir_codec import sir_pkg::*; #(
  parameter int DIV_W = SIR_DIV_W,
  parameter int OVS   = SIR_OVS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             baud16_tick_i,
  input  logic             lp_ref_tick_i,
  input  logic [DIV_W-1:0] lp_div_i,
  input  logic             uart_en_i,
  input  logic             sir_en_i,
  input  logic             lp_mode_i,
  input  logic             loop_en_i,
  input  logic             sir_test_i,
  input  logic             uart_txd_i,
  input  logic             line_rxd_i,
  input  logic             sir_rxn_i,
  output logic             sir_tx_o,
  output logic             line_txd_o,
  output logic             rx_bit_o
);
  logic active, loop, dec_in, dec_rx, lp_tick, dec_fall;

  assign active = uart_en_i & sir_en_i;
  assign loop   = active & loop_en_i & sir_test_i;
  assign dec_in = !active ? 1'b1 : (loop ? ~sir_tx_o : sir_rxn_i);

  sir_lp_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .ref_tick_i (lp_ref_tick_i),
    .div_i      (lp_div_i),
    .tick_o     (lp_tick)
  );

  sir_enc #(.OVS(OVS)) u_enc (
    .clk_i, .rst_ni,
    .tick16_i  (baud16_tick_i),
    .lp_tick_i (lp_tick),
    .active_i  (active),
    .lp_mode_i (lp_mode_i),
    .lp_ok_i   (|lp_div_i),
    .txd_i     (uart_txd_i),
    .pulse_o   (sir_tx_o)
  );

  sir_dec #(.OVS(OVS), .HOLD_TICKS(OVS + 1)) u_dec (
    .clk_i, .rst_ni,
    .tick16_i (baud16_tick_i),
    .active_i (active),
    .rxn_i    (dec_in),
    .rx_o     (dec_rx),
    .fall_o   (dec_fall)
  );

  assign line_txd_o = active ? 1'b1 : uart_txd_i;
  assign rx_bit_o   = active ? dec_rx : line_rxd_i;
endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             baud16_tick_i,
  input logic [DIV_W-1:0] lp_div_i,
  input logic             uart_en_i,
  input logic             sir_en_i,
  input logic             lp_mode_i,
  input logic             uart_txd_i,
  input logic             line_rxd_i,
  input logic             sir_tx_o,
  input logic             line_txd_o,
  input logic             rx_bit_o,
  input logic             lp_tick,
  input logic             dec_fall
);
  logic act;
  assign act = uart_en_i & sir_en_i;

  p_norm_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && $past(act) && !lp_mode_i && !$past(lp_mode_i) && $rose(sir_tx_o)
      |-> $past(baud16_tick_i) && !$past(uart_txd_i));

  p_lp_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && $past(act) && lp_mode_i && $past(lp_mode_i) && $rose(sir_tx_o)
      |-> $past(lp_tick));

  p_lp_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && $past(act) && lp_mode_i && $past(lp_mode_i) && (lp_div_i != 0)
      && $past(lp_div_i != 0) && $fell(sir_tx_o) |-> $past(lp_tick));

  p_div_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_div_i == 0) |-> !lp_tick);

  p_dark_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> !sir_tx_o && rx_bit_o == line_rxd_i);

  p_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> line_txd_o);

  p_uart_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uart_en_i |-> line_txd_o == uart_txd_i);

  p_dec_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && $past(act) && $fell(rx_bit_o) |-> $past(dec_fall));
endmodule

bind sir_codec sir_codec_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i, .rst_ni, .baud16_tick_i, .lp_div_i, .uart_en_i, .sir_en_i,
  .lp_mode_i, .uart_txd_i, .line_rxd_i, .sir_tx_o, .line_txd_o, .rx_bit_o,
  .lp_tick, .dec_fall
);

// File: tb/tb_sir_codec.sv
module tb_sir_codec;
  localparam int OVS   = 16;
  localparam int LPR   = 2;
  localparam int DIVV  = 3;
  localparam int LIMIT = 150000;

  typedef struct {int lo; int hi; string req;} exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] lp_div = 8'(DIVV);
  logic uart_en = 1'b1, sir_en = 1'b1, lp_mode = 1'b0, loop_en = 1'b0, sir_test = 1'b0;
  logic txd = 1'b1, line_rxd = 1'b1, sir_rxn = 1'b1;
  logic sir_tx, line_txd, rx_bit;
  int   td = 4, tc = 0, lc = 0;
  logic baud16, lp_ref;

  exp_t  q_tx[$], q_rx[$];
  exp_t  e;
  int    n_chk = 0, n_bad = 0, tx_seen = 0, tx_w = 0, rx_w = 0;
  bit    rx_mon = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tc <= (tc >= td - 1) ? 0 : tc + 1;
    lc <= (lc >= LPR - 1) ? 0 : lc + 1;
  end
  assign baud16 = rst_n && (tc == 0);
  assign lp_ref = rst_n && (lc == 0);

  sir_codec dut (
    .clk_i(clk), .rst_ni(rst_n), .baud16_tick_i(baud16), .lp_ref_tick_i(lp_ref),
    .lp_div_i(lp_div), .uart_en_i(uart_en), .sir_en_i(sir_en), .lp_mode_i(lp_mode),
    .loop_en_i(loop_en), .sir_test_i(sir_test), .uart_txd_i(txd),
    .line_rxd_i(line_rxd), .sir_rxn_i(sir_rxn), .sir_tx_o(sir_tx),
    .line_txd_o(line_txd), .rx_bit_o(rx_bit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: measures pulse widths and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (sir_tx) tx_w++;
      else if (tx_w > 0) begin
        tx_seen++;
        if (q_tx.size() == 0) check(1'b0, cur_req, "unexpected sir_tx pulse", tx_w, 0);
        else begin
          e = q_tx.pop_front();
          check(tx_w >= e.lo && tx_w <= e.hi, e.req, "sir_tx pulse width", tx_w, e.lo);
        end
        tx_w = 0;
      end
      if (rx_mon && !rx_bit) rx_w++;
      else if (rx_w > 0) begin
        if (q_rx.size() == 0) check(1'b0, cur_req, "unexpected rx low", rx_w, 0);
        else begin
          e = q_rx.pop_front();
          check(rx_w >= e.lo && rx_w <= e.hi, e.req, "rx low width", rx_w, e.lo);
        end
        rx_w = 0;
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) @(negedge clk iff baud16);
  endtask

  function automatic string line_tag();
    if (!uart_en) return "R6";
    return sir_en ? "R5" : "R4";
  endfunction

  // driver: one bit per 16 ticks, pushing expected items
  task automatic send_bits(input logic [15:0] b, input int n, input int w,
                           input bit exp_rx, input string req);
    bit act;
    act = uart_en & sir_en;
    wait_ticks(1);
    for (int i = 0; i < n; i++) begin
      txd = b[i];
      if (!b[i] && w > 0) q_tx.push_back('{lo: w, hi: w, req: req});
      if (!b[i] && exp_rx) q_rx.push_back('{lo: 16*td-2, hi: 18*td, req: "R9"});
      @(negedge clk);
      check(line_txd == (act ? 1'b1 : b[i]), line_tag(), "line_txd_o",
            int'(line_txd), int'(act ? 1'b1 : b[i]));
      wait_ticks(OVS);
    end
    txd = 1'b1;
    wait_ticks(2 * OVS);
  endtask

  task automatic rx_pulse(input int len);
    sir_rxn = 1'b0;
    repeat (len) @(negedge clk);
    sir_rxn = 1'b1;
  endtask

  initial begin
    int seen;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(sir_tx == 1'b0, "R10", "sir_tx_o in reset", int'(sir_tx), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sir_tx == 1'b0, "R10", "sir_tx_o after reset", int'(sir_tx), 0);
    check(rx_bit == 1'b1, "R10", "rx_bit_o after reset", int'(rx_bit), 1);
    rx_mon = 1'b1;

    // R1: normal pulses at two tick rates
    cur_req = "R1";
    send_bits(16'b1011_0010, 8, 3*td, 1'b0, "R1");
    send_bits(16'b0000_0001, 1, 0, 1'b0, "R1");  // high bit: no pulse
    td = 8;
    send_bits(16'b1110_0110, 8, 3*td, 1'b0, "R1");

    // R2: low-power width independent of tick rate
    cur_req = "R2";
    lp_mode = 1'b1;
    send_bits(16'b1101_0110, 8, 3*LPR*DIVV, 1'b0, "R2");
    td = 4;
    send_bits(16'b0101_1010, 8, 3*LPR*DIVV, 1'b0, "R2");

    // R3: divisor 5 changes width, divisor 0 sends nothing
    cur_req = "R3";
    lp_div = 8'd5;
    send_bits(16'b1111_1110, 8, 3*LPR*5, 1'b0, "R3");
    lp_div = 8'd0;
    seen = tx_seen;
    send_bits(16'b1010_0100, 8, 0, 1'b0, "R3");
    check(tx_seen == seen, "R3", "pulses with divisor 0", tx_seen - seen, 0);
    lp_div = 8'(DIVV);
    lp_mode = 1'b0;

    // R7: single received pulse
    cur_req = "R7";
    wait_ticks(1);
    q_rx.push_back('{lo: 16*td-2, hi: 18*td, req: "R7"});
    sir_rxn = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_bit == 1'b0, "R7", "rx_bit_o 3 cycles after edge", int'(rx_bit), 0);
    sir_rxn = 1'b1;
    wait_ticks(2*OVS);

    // R8: pulses in consecutive bit periods merge
    cur_req = "R8";
    q_rx.push_back('{lo: 32*td-2, hi: 34*td, req: "R8"});
    rx_pulse(3);
    wait_ticks(OVS);
    rx_pulse(3);
    wait_ticks(3*OVS);

    // R5: wired RX ignored while SIR active
    cur_req = "R5";
    line_rxd = 1'b0;
    repeat (20) @(negedge clk);
    check(rx_bit == 1'b1, "R5", "rx_bit_o with line_rxd_i low", int'(rx_bit), 1);
    line_rxd = 1'b1;

    // R9: loopback, external input ignored
    cur_req = "R9";
    loop_en = 1'b1; sir_test = 1'b1;
    send_bits(16'b1011_1101, 8, 3*td, 1'b1, "R9");
    rx_pulse(3);
    wait_ticks(2*OVS);
    check(q_rx.size() == 0, "R9", "pending loopback rx items", q_rx.size(), 0);
    sir_test = 1'b0;  // only loop_en: no loopback
    send_bits(16'b1111_1011, 8, 3*td, 1'b0, "R9");
    loop_en = 1'b0;

    // R4 / R6: path inactive, wired lines pass through
    rx_mon = 1'b0;
    for (int k = 0; k < 2; k++) begin
      string t;
      t = (k == 0) ? "R4" : "R6";
      cur_req = t;
      if (k == 0) begin sir_en = 1'b0; uart_en = 1'b1; end
      else        begin sir_en = 1'b1; uart_en = 1'b0; end
      seen = tx_seen;
      send_bits(16'b0100_0010, 8, 0, 1'b0, t);
      check(tx_seen == seen, t, "pulses while inactive", tx_seen - seen, 0);
      line_rxd = 1'b0;
      @(negedge clk);
      check(rx_bit == 1'b0, t, "rx_bit_o follows line low", int'(rx_bit), 0);
      line_rxd = 1'b1;
      rx_pulse(3);
      repeat (6) @(negedge clk);
      check(rx_bit == 1'b1, t, "rx_bit_o after ignored SIR pulse", int'(rx_bit), 1);
    end
    uart_en = 1'b1; sir_en = 1'b1;
    repeat (10) @(negedge clk);

    check(q_tx.size() == 0, "R1", "pending tx items", q_tx.size(), 0);
    check(q_rx.size() == 0, "R7", "pending rx items", q_rx.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d cycles", LIMIT, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule